// File: doc/BRIEF.md
# Single-Precision Floating-Point Add/Subtract Unit

This block adds or subtracts two 32-bit binary floating-point values. Each operand carries a sign in bit 31, a biased exponent (bias 127) in bits 30:23 and a 23-bit fraction in bits 22:0. Normal numbers have an implicit leading one. The unit first orders the two operands by magnitude. It then shifts the smaller significand right by the exponent gap and combines the magnitudes with an add or a subtract. The sum is renormalised with a leading-zero count, and the result is rounded to nearest, ties to even, from three extra low-order bits.

The unit is a two-stage pipeline with no handshake. A new operation may be presented on every clock, and its result and flags appear two rising edges later. Zero, infinity and NaN operands are handled on a separate path. Operands with a zero exponent and a nonzero fraction (denormals) are treated as zeros of the same sign. Results that would be denormal are flushed to zero.

Top module: `fp_add_sub`

## Requirements
- R1: For finite normal operands, `result` is the sum A+B when `op_sub`=0, or A−B when `op_sub`=1, rounded to the nearest representable value. Fields: sign bit 31, exponent 30:23 with bias 127, fraction 22:0.
- R2: The operand with the smaller magnitude is shifted right by the exponent difference. All bits shifted out below the round position set a sticky bit, including gaps larger than the significand width.
- R3: The effective operation is the XOR of the sign of A, the sign of B and `op_sub`. The result sign is that of the operand with the larger magnitude, with B's sign inverted when subtracting.
- R4: A carry out of the magnitude sum shifts the significand right by one and raises the exponent by one. A cancellation shifts it left by its leading-zero count and lowers the exponent by the same amount.
- R5: Rounding uses a guard bit, a round bit and a sticky bit. An exact halfway case rounds to the value with an even last fraction bit.
- R6: When rounding carries out of the significand, the significand is renormalised to 1.0 and the exponent is raised by one.
- R7: An exact cancellation gives +0. The sum of two zeros is negative only when both effective signs are negative.
- R8: An infinite operand gives an infinity with that operand's effective sign. Two infinities with the same effective sign give that infinity.
- R9: Any NaN operand gives the quiet NaN 0x7FC00000 with no flags set. Infinities with opposite effective signs give 0x7FC00000 and set the invalid flag.
- R10: A rounded exponent of 255 or more gives a signed infinity and sets the overflow and inexact flags.
- R11: An operand with exponent 0 counts as a zero of its sign. A nonzero result whose exponent would fall below 1 becomes a zero with the result sign and sets the underflow and inexact flags.
- R12: `flags` is {invalid, overflow, underflow, inexact}, with bit 3 = invalid and bit 0 = inexact. Inexact is set when any guard, round or sticky bit is nonzero before rounding.
- R13: `result` and `flags` are zero while `rst` is high and in the cycle after it. An operation presented before a rising edge appears at the outputs after the second rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| op_sub | input | 1 | 1 selects A−B, 0 selects A+B |
| result | output | 32 | Registered rounded result |
| flags | output | 4 | Registered {invalid, overflow, underflow, inexact} |

## Verification
The bench builds the unit with its default widths: an 8-bit exponent and a 23-bit fraction. At these widths the exponent gap can reach 254, far past the 27-bit aligned significand, so the bench reaches the sticky path for large gaps. It also reaches both ends of the exponent range, the overflow to infinity at the top and the flush of cancelled results below 2^-126 at the bottom. A reference model built on double-precision arithmetic holds every sum exactly for gaps up to 28. Ties, rounding carries and deep cancellations can therefore be compared bit for bit against random and directed operands.

// File: rtl/fp_add_sub_pkg.sv
package fp_add_sub_pkg;

  // Exception flags, packed so that invalid lands in bit 3 and inexact in bit 0.
  typedef struct packed {
    logic invalid;
    logic overflow;
    logic underflow;
    logic inexact;
  } fp_flags_t;

endpackage

// File: rtl/fp_add_sub_lzc.sv
module fp_add_sub_lzc #(
  parameter int W  = 27,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] zeros
);

  // The last set bit scanned upward is the most significant one.
  always_comb begin
    zeros = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) zeros = CW'(W - 1 - i);
    end
  end

endmodule

// File: rtl/fp_add_sub_unpack.sv
module fp_add_sub_unpack
  import fp_add_sub_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0]   a,
  input  logic [EXP_W+FRAC_W:0]   b,
  input  logic                    sub,
  output logic                    special,
  output logic [EXP_W+FRAC_W:0]   special_res,
  output fp_flags_t               special_flags,
  output logic                    x_sign,
  output logic [EXP_W-1:0]        x_exp,
  output logic                    eff_sub,
  output logic [FRAC_W+3:0]       x_ext,
  output logic [FRAC_W+3:0]       y_ext
);

  localparam int W     = 1 + EXP_W + FRAC_W;
  localparam int EXT_W = FRAC_W + 4;
  localparam logic [EXP_W-1:0] EMAX    = '1;
  localparam logic [EXP_W-1:0] EXT_LIM = EXP_W'(EXT_W);
  localparam logic [W-1:0] QNAN = {1'b0, EMAX, 1'b1, {(FRAC_W-1){1'b0}}};

  logic             sa, sb;
  logic [EXP_W-1:0] ea, eb, ye, shamt;
  logic [W-2:0]     ma, mb, mx, my;
  logic             nan_a, nan_b, inf_a, inf_b, zero_a, zero_b, a_big;
  logic [EXT_W-1:0] y_raw, y_sh;
  logic             lost;

  assign sa = a[W-1];
  assign sb = b[W-1] ^ sub;
  assign ea = a[W-2:FRAC_W];
  assign eb = b[W-2:FRAC_W];

  assign zero_a = (ea == '0);
  assign zero_b = (eb == '0);
  assign inf_a  = (ea == EMAX) && (a[FRAC_W-1:0] == '0);
  assign inf_b  = (eb == EMAX) && (b[FRAC_W-1:0] == '0);
  assign nan_a  = (ea == EMAX) && (a[FRAC_W-1:0] != '0);
  assign nan_b  = (eb == EMAX) && (b[FRAC_W-1:0] != '0);

  // Denormals are flushed: an all-zero exponent zeroes the whole magnitude.
  assign ma = zero_a ? '0 : a[W-2:0];
  assign mb = zero_b ? '0 : b[W-2:0];

  assign a_big = (ma >= mb);
  assign mx    = a_big ? ma : mb;
  assign my    = a_big ? mb : ma;
  assign x_sign  = a_big ? sa : sb;
  assign eff_sub = sa ^ sb;
  assign x_exp   = mx[W-2:FRAC_W];
  assign ye      = my[W-2:FRAC_W];
  assign shamt   = x_exp - ye;

  assign x_ext = {(x_exp != '0), mx[FRAC_W-1:0], 3'b000};
  assign y_raw = {(ye != '0), my[FRAC_W-1:0], 3'b000};

  // Right alignment; everything shifted past bit 0 collapses into the sticky bit.
  always_comb begin
    if (shamt >= EXT_LIM) begin
      y_sh = '0;
      lost = |y_raw;
    end else begin
      y_sh = y_raw >> shamt;
      lost = |(y_raw & ~({EXT_W{1'b1}} << shamt));
    end
  end

  assign y_ext = {y_sh[EXT_W-1:1], y_sh[0] | lost};

  always_comb begin
    special       = 1'b1;
    special_res   = '0;
    special_flags = '0;
    if (nan_a || nan_b) begin
      special_res = QNAN;
    end else if (inf_a && inf_b && (sa != sb)) begin
      special_res           = QNAN;
      special_flags.invalid = 1'b1;
    end else if (inf_a) begin
      special_res = {sa, EMAX, {FRAC_W{1'b0}}};
    end else if (inf_b) begin
      special_res = {sb, EMAX, {FRAC_W{1'b0}}};
    end else if (zero_a && zero_b) begin
      special_res = {sa & sb, {(W-1){1'b0}}};
    end else begin
      special = 1'b0;
    end
  end

endmodule

// File: rtl/fp_add_sub_finish.sv
module fp_add_sub_finish
  import fp_add_sub_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                  x_sign,
  input  logic [EXP_W-1:0]      x_exp,
  input  logic                  eff_sub,
  input  logic [FRAC_W+3:0]     x_ext,
  input  logic [FRAC_W+3:0]     y_ext,
  output logic [EXP_W+FRAC_W:0] res,
  output fp_flags_t             flags
);

  localparam int SIG_W = FRAC_W + 1;
  localparam int EXT_W = FRAC_W + 4;
  localparam int CW    = $clog2(EXT_W + 1);
  localparam int EW    = EXP_W + 2;
  localparam int EMAX_I = (1 << EXP_W) - 1;
  localparam logic [EXP_W-1:0] EMAX = '1;

  logic [EXT_W:0]          sum;
  logic [CW-1:0]           lz;
  logic [EXT_W-1:0]        norm;
  logic signed [EW-1:0]    e_n, e_f;
  logic [SIG_W-1:0]        keep;
  logic                    g, r, s, up;
  logic [SIG_W:0]          rnd;
  logic [FRAC_W-1:0]       frac_f;

  // Operands arrive ordered by magnitude, so the difference is never negative.
  assign sum = eff_sub ? ({1'b0, x_ext} - {1'b0, y_ext})
                       : ({1'b0, x_ext} + {1'b0, y_ext});

  fp_add_sub_lzc #(.W(EXT_W), .CW(CW)) u_lzc (
    .vec   (sum[EXT_W-1:0]),
    .zeros (lz)
  );

  always_comb begin
    if (sum[EXT_W]) begin
      norm = {sum[EXT_W:2], sum[1] | sum[0]};
      e_n  = EW'(x_exp) + EW'(1);
    end else begin
      norm = sum[EXT_W-1:0] << lz;
      e_n  = EW'(x_exp) - EW'(lz);
    end
  end

  assign keep = norm[EXT_W-1:3];
  assign g    = norm[2];
  assign r    = norm[1];
  assign s    = norm[0];
  assign up   = g & (r | s | keep[0]);
  assign rnd  = {1'b0, keep} + (SIG_W+1)'(up);

  always_comb begin
    if (rnd[SIG_W]) begin
      frac_f = rnd[FRAC_W:1];
      e_f    = e_n + EW'(1);
    end else begin
      frac_f = rnd[FRAC_W-1:0];
      e_f    = e_n;
    end
  end

  always_comb begin
    flags = '0;
    if (sum == '0) begin
      res = '0;
    end else if (e_f >= EW'(EMAX_I)) begin
      res            = {x_sign, EMAX, {FRAC_W{1'b0}}};
      flags.overflow = 1'b1;
      flags.inexact  = 1'b1;
    end else if (e_f < EW'(1)) begin
      res             = {x_sign, {(EXP_W+FRAC_W){1'b0}}};
      flags.underflow = 1'b1;
      flags.inexact   = 1'b1;
    end else begin
      res           = {x_sign, e_f[EXP_W-1:0], frac_f};
      flags.inexact = g | r | s;
    end
  end

endmodule

// File: rtl/fp_add_sub.sv
module fp_add_sub
  import fp_add_sub_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [EXP_W+FRAC_W:0]     op_a,
  input  logic [EXP_W+FRAC_W:0]     op_b,
  input  logic                      op_sub,
  output logic [EXP_W+FRAC_W:0]     result,
  output logic [3:0]                flags
);

  localparam int W     = 1 + EXP_W + FRAC_W;
  localparam int EXT_W = FRAC_W + 4;

  logic             c_special, c_xs, c_sub;
  logic [W-1:0]     c_sres;
  fp_flags_t        c_sflags;
  logic [EXP_W-1:0] c_xe;
  logic [EXT_W-1:0] c_x, c_y;

  logic             s1_special, s1_xs, s1_sub;
  logic [W-1:0]     s1_sres;
  fp_flags_t        s1_sflags;
  logic [EXP_W-1:0] s1_xe;
  logic [EXT_W-1:0] s1_x, s1_y;

  logic [W-1:0]     f_res;
  fp_flags_t        f_flags;
  fp_flags_t        out_flags;

  fp_add_sub_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack (
    .a             (op_a),
    .b             (op_b),
    .sub           (op_sub),
    .special       (c_special),
    .special_res   (c_sres),
    .special_flags (c_sflags),
    .x_sign        (c_xs),
    .x_exp         (c_xe),
    .eff_sub       (c_sub),
    .x_ext         (c_x),
    .y_ext         (c_y)
  );

  // Stage 1: classified, ordered and aligned operands.
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_special <= 1'b0;
      s1_sres    <= '0;
      s1_sflags  <= '0;
      s1_xs      <= 1'b0;
      s1_xe      <= '0;
      s1_sub     <= 1'b0;
      s1_x       <= '0;
      s1_y       <= '0;
    end else begin
      s1_special <= c_special;
      s1_sres    <= c_sres;
      s1_sflags  <= c_sflags;
      s1_xs      <= c_xs;
      s1_xe      <= c_xe;
      s1_sub     <= c_sub;
      s1_x       <= c_x;
      s1_y       <= c_y;
    end
  end

  fp_add_sub_finish #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_finish (
    .x_sign  (s1_xs),
    .x_exp   (s1_xe),
    .eff_sub (s1_sub),
    .x_ext   (s1_x),
    .y_ext   (s1_y),
    .res     (f_res),
    .flags   (f_flags)
  );

  // Stage 2: registered outputs.
  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      out_flags <= '0;
    end else begin
      result    <= s1_special ? s1_sres   : f_res;
      out_flags <= s1_special ? s1_sflags : f_flags;
    end
  end

  assign flags = out_flags;

endmodule

// File: rtl/fp_add_sub_chk.sv
module fp_add_sub_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input logic                  clk,
  input logic                  rst,
  input logic [EXP_W+FRAC_W:0] op_a,
  input logic [EXP_W+FRAC_W:0] op_b,
  input logic [EXP_W+FRAC_W:0] result,
  input logic [3:0]            flags
);

  localparam int W = 1 + EXP_W + FRAC_W;
  localparam logic [EXP_W-1:0] EMAX = '1;
  localparam logic [W-1:0] QNAN = {1'b0, EMAX, 1'b1, {(FRAC_W-1){1'b0}}};

  logic [1:0] cyc;
  always_ff @(posedge clk) begin
    if (rst) cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  function automatic logic is_nan(input logic [W-1:0] v);
    return (v[W-2:FRAC_W] == EMAX) && (v[FRAC_W-1:0] != '0);
  endfunction

  function automatic logic is_fin_normal(input logic [W-1:0] v);
    return (v[W-2:FRAC_W] != '0) && (v[W-2:FRAC_W] != EMAX);
  endfunction

  AST_NAN_IN_QNAN: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 2'd2 && (is_nan($past(op_a, 2)) || is_nan($past(op_b, 2))))
      |-> (result == QNAN && flags == 4'b0000)); // R9

  AST_INVALID_QNAN: assert property (@(posedge clk) disable iff (rst)
    flags[3] |-> (result == QNAN)); // R9

  AST_OVF_INF: assert property (@(posedge clk) disable iff (rst)
    flags[2] |-> (result[W-2:0] == {EMAX, {FRAC_W{1'b0}}} && flags[0])); // R10

  AST_UNF_ZERO: assert property (@(posedge clk) disable iff (rst)
    flags[1] |-> (result[W-2:0] == '0 && flags[0])); // R11

  AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 2'd2 && $past(op_b[W-2:FRAC_W], 2) == '0 && is_fin_normal($past(op_a, 2)))
      |-> (result == $past(op_a, 2) && flags == 4'b0000)); // R11

  AST_ONE_EXCEPTION: assert property (@(posedge clk) disable iff (rst)
    $countones(flags[3:1]) <= 1); // R12

endmodule

bind fp_add_sub fp_add_sub_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .op_a   (op_a),
  .op_b   (op_b),
  .result (result),
  .flags  (flags)
);

// File: tb/fp_add_sub_bench.sv
`timescale 1ns/1ps
module fp_add_sub_bench;

  localparam logic [31:0] QNAN = 32'h7FC00000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] op_a = '0, op_b = '0;
  logic        op_sub = 1'b0;
  logic [31:0] result;
  logic [3:0]  flags;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fp_add_sub u_fp_add_sub (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b),
    .op_sub(op_sub), .result(result), .flags(flags)
  );

  function automatic real to_real(input logic s, input logic [7:0] e, input logic [22:0] f);
    logic [10:0] de;
    if (e == 8'd0) return 0.0;
    de = 11'(int'(e) - 127 + 1023);
    return $bitstoreal({s, de, f, 29'b0});
  endfunction

  // Reference: exact sum in double precision, then rounded to single by hand.
  function automatic logic [35:0] model(input logic [31:0] a, input logic [31:0] b, input logic sub);
    logic sa, sb, inx, up;
    logic [7:0] ea, eb;
    logic [22:0] fa, fb;
    real sres;
    logic [63:0] db;
    int e, gap;
    logic [23:0] keep;
    logic [28:0] rem;
    logic [24:0] k25;
    sa = a[31]; sb = b[31] ^ sub;
    ea = a[30:23]; eb = b[30:23];
    fa = a[22:0]; fb = b[22:0];
    if ((ea == 8'hFF && fa != 0) || (eb == 8'hFF && fb != 0)) return {4'b0000, QNAN};
    if (ea == 8'hFF && eb == 8'hFF)
      return (sa != sb) ? {4'b1000, QNAN} : {4'b0000, sa, 8'hFF, 23'b0};
    if (ea == 8'hFF) return {4'b0000, sa, 8'hFF, 23'b0};
    if (eb == 8'hFF) return {4'b0000, sb, 8'hFF, 23'b0};
    if (ea == 8'd0 && eb == 8'd0) return {4'b0000, sa & sb, 31'b0};
    sres = to_real(sa, ea, fa) + to_real(sb, eb, fb);
    if (sres == 0.0) return 36'd0;
    db   = $realtobits(sres);
    e    = int'(db[62:52]) - 1023 + 127;
    keep = {1'b1, db[51:29]};
    rem  = db[28:0];
    inx  = (rem != 0);
    up   = rem[28] & ((|rem[27:0]) | keep[0]);
    k25  = {1'b0, keep} + 25'(up);
    if (k25[24]) begin keep = k25[24:1]; e = e + 1; end
    else keep = k25[23:0];
    gap = (ea > eb) ? int'(ea) - int'(eb) : int'(eb) - int'(ea);
    if (ea != 0 && eb != 0 && gap > 28) inx = 1'b1;
    if (e >= 255) return {4'b0101, db[63], 8'hFF, 23'b0};
    if (e <= 0)   return {4'b0011, db[63], 31'b0};
    return {3'b000, inx, db[63], 8'(e), keep[22:0]};
  endfunction

  task automatic run(input logic [31:0] a, input logic [31:0] b, input logic sub,
                     input logic [35:0] exp_v, input string tag);
    @(negedge clk);
    op_a = a; op_b = b; op_sub = sub;
    @(negedge clk);
    @(negedge clk);
    checks++;
    if ({flags, result} !== exp_v) begin
      errors++;
      $display("FAIL %s: a=%h b=%h sub=%0d actual flags=%b result=%h expected flags=%b result=%h",
               tag, a, b, sub, flags, result, exp_v[35:32], exp_v[31:0]);
    end
  endtask

  task automatic run_model(input logic [31:0] a, input logic [31:0] b, input logic sub, input string tag);
    run(a, b, sub, model(a, b, sub), tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    checks++;
    $display("FAIL R13 watchdog: actual=hung expected=complete");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    op_a = 32'h3F800000; op_b = 32'h3F800000;
    repeat (3) @(negedge clk);
    checks++;
    if (result !== 32'd0 || flags !== 4'd0) begin
      errors++;
      $display("FAIL R13 reset: actual result=%h flags=%b expected result=00000000 flags=0000", result, flags);
    end
    rst = 1'b0;
    checks++;
    @(negedge clk);
    if (result !== 32'd0 || flags !== 4'd0) begin
      errors++;
      $display("FAIL R13 first cycle: actual result=%h flags=%b expected 0", result, flags);
    end

    run(32'h3F800000, 32'h40000000, 1'b0, {4'b0000, 32'h40400000}, "R1 1+2");
    run(32'h3F800000, 32'h3F800000, 1'b0, {4'b0000, 32'h40000000}, "R12 exact 1+1");
    run(32'h3FC00000, 32'h3FC00000, 1'b0, {4'b0000, 32'h40400000}, "R4 carry-out");
    run(32'h3F800000, 32'h40000000, 1'b1, {4'b0000, 32'hBF800000}, "R3 1-2");
    run(32'hC0000000, 32'h3F800000, 1'b0, {4'b0000, 32'hBF800000}, "R3 -2+1");
    run(32'h3F800001, 32'h3F800000, 1'b1, {4'b0000, 32'h34000000}, "R4 cancellation");
    run(32'h3F800000, 32'h33800000, 1'b0, {4'b0001, 32'h3F800000}, "R5 tie down to even");
    run(32'h3F800001, 32'h33800000, 1'b0, {4'b0001, 32'h3F800002}, "R5 tie up to even");
    run(32'h3F7FFFFF, 32'h33000000, 1'b0, {4'b0001, 32'h3F800000}, "R6 round carry");
    run(32'h4B800000, 32'h3F800000, 1'b0, {4'b0001, 32'h4B800000}, "R2 gap 24");
    run(32'h7F000000, 32'h00800000, 1'b0, {4'b0001, 32'h7F000000}, "R2 huge gap");
    run(32'h40490FDB, 32'h40490FDB, 1'b1, {4'b0000, 32'h00000000}, "R7 exact cancel");
    run(32'h80000000, 32'h80000000, 1'b0, {4'b0000, 32'h80000000}, "R7 -0 + -0");
    run(32'h80000000, 32'h00000000, 1'b1, {4'b0000, 32'h80000000}, "R7 -0 - +0");
    run(32'h00000000, 32'h80000000, 1'b0, {4'b0000, 32'h00000000}, "R7 +0 + -0");
    run(32'h7F800000, 32'h3F800000, 1'b0, {4'b0000, 32'h7F800000}, "R8 inf+1");
    run(32'h3F800000, 32'h7F800000, 1'b1, {4'b0000, 32'hFF800000}, "R8 1-inf");
    run(32'h7F800000, 32'h7F800000, 1'b0, {4'b0000, 32'h7F800000}, "R8 inf+inf");
    run(32'h7F800000, 32'h7F800000, 1'b1, {4'b1000, QNAN}, "R9 inf-inf");
    run(32'h7FC12345, 32'h3F800000, 1'b0, {4'b0000, QNAN}, "R9 NaN in");
    run(32'h7F800001, 32'h7F800000, 1'b0, {4'b0000, QNAN}, "R9 NaN plus inf");
    run(32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, {4'b0101, 32'h7F800000}, "R10 overflow +");
    run(32'hFF7FFFFF, 32'h7F7FFFFF, 1'b1, {4'b0101, 32'hFF800000}, "R10 overflow -");
    run(32'h00000005, 32'h3F800000, 1'b0, {4'b0000, 32'h3F800000}, "R11 denormal in");
    run(32'h00800001, 32'h00800000, 1'b1, {4'b0011, 32'h00000000}, "R11 underflow +");
    run(32'h80800001, 32'h80800000, 1'b1, {4'b0011, 32'h80000000}, "R11 underflow -");

    for (int n = 0; n < 800; n++) begin
      logic [31:0] a, b;
      logic [7:0] e2;
      int mode;
      a = $urandom;
      b = $urandom;
      mode = int'($urandom % 5);
      if (mode == 1) begin
        e2 = a[30:23] + 8'($urandom % 8) - 8'd4;
        b[30:23] = e2;
      end else if (mode == 2) begin
        b = a ^ (32'h1 << ($urandom % 12));
      end else if (mode == 3) begin
        a[30:23] = 8'hF0 + 8'($urandom % 15);
        b[30:23] = 8'hF0 + 8'($urandom % 15);
      end else if (mode == 4) begin
        a[30:23] = 8'($urandom % 4);
        b = a ^ (32'h1 << ($urandom % 23));
      end
      run_model(a, b, 1'($urandom % 2), "R1 random vs model");
    end

    finish_run();
  end

endmodule